// File: doc/BRIEF.md
# Port Pin Role Selector with Buffer Flags and DMA Request

This block owns four general-purpose output bits of a slave controller's port and lets firmware hand each of them over to a host-facing role. After reset all four bits are ordinary latched outputs that show whatever the port register holds. Two single-byte commands, arriving on an opcode input with a valid strobe, change the roles. The flag-enable command turns bits 0 and 1 into gated indications of the output buffer being full and of the input buffer having room. The DMA-enable command turns bit 2 into a DMA request and bit 3 into an input that carries the active-low DMA acknowledge.

In flag mode a port write does not drive the pin directly. Instead, the written bit acts as an enable: a 1 routes the status indication onto the pin, and a 0 forces the pin low. In DMA mode, writing a 1 to bit 2 raises the request. The request falls once the host finishes an acknowledged transfer, which is the trailing edge of a read or write strobe seen while acknowledge is low. It also falls when the DMA-enable command is issued again. Host lines pass through a configurable synchronizer before use.

Top module: `port_role_mux`

## Requirements
- R1: After reset, pin_out equals the RST_PORT parameter (default 4'b1111), pin_oe is 4'b1111, both modes are off and the DMA request is low.
- R2: Outside any mode, a port write (port_we high) sets pin_out to port_wdata one clock later, and ibf/obf have no effect on the pins.
- R3: Opcode 0xF5 with op_valid enables flag mode from the next clock; then pin_out[0] equals port bit 0 AND obf.
- R4: In flag mode pin_out[1] equals port bit 1 AND NOT ibf; pins 2 and 3 keep showing their port bits.
- R5: The DMA-enable opcode (parameter OPC_DMA, default 0xE5) enables DMA mode from the next clock; then pin_oe is 4'b0111 (pin 3 is an input) and pin_out[2] shows the DMA request.
- R6: In DMA mode a port write with bit 2 set raises the request on the next clock; a port write with bit 2 clear leaves it unchanged.
- R7: With pin3_in (acknowledge, active low) low, the release of host_rd_n clears the request SYNC_STAGES+1 clocks after the first edge that samples the release.
- R8: With pin3_in low, the release of host_wr_n clears the request with the same timing as R7.
- R9: A read or write strobe with pin3_in high, or pin3_in low with no strobe, never clears the request.
- R10: Issuing the DMA-enable opcode while in DMA mode clears the request on the next clock and keeps DMA mode on.
- R11: When a request-raising port write lands in the same clock as a clearing event (acknowledged strobe end or DMA-enable opcode), the request is high afterwards.
- R12: Opcodes other than 0xF5 and OPC_DMA, including the status-load code 0x90, change no mode; once enabled, each mode stays on until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode strobe, one clock per command |
| opcode | input | OPC_W | Executed command byte |
| port_we | input | 1 | Port register write strobe |
| port_wdata | input | 4 | Port register write data, bit 0 to bit 3 |
| ibf | input | 1 | Input buffer full status |
| obf | input | 1 | Output buffer full status |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| pin3_in | input | 1 | Pin 3 input level, DMA acknowledge (active low) in DMA mode |
| pin_out | output | 4 | Output levels of the four pins |
| pin_oe | output | 4 | Output enables of the four pins |

## Verification
The request-raising port write and a request-clearing event can land in the same clock. The clearing event is either the trailing edge of an acknowledged strobe or a repeat of the DMA-enable command. The bench provokes the first case by releasing an acknowledged read and counting the synchronizer and edge-detect stages. It then issues the port write exactly in the clock where the clear would take effect. It provokes the second case by driving the opcode and the port write together. In both cases the request must stay high afterwards, and it must stay high for several more clocks, which shows that no stale clear follows.

// File: rtl/port_role_pkg.sv
package port_role_pkg;
   localparam int OPC_W_DEF = 8;
   localparam logic [7:0] OPC_FLAGS_DEF  = 8'hF5;
   localparam logic [7:0] OPC_DMA_DEF    = 8'hE5;
   localparam logic [7:0] OPC_STATUS_DEF = 8'h90;

   typedef enum logic [1:0] {
      CMD_NONE,
      CMD_FLAGS,
      CMD_DMA,
      CMD_STATUS
   } cmd_e;
endpackage

// File: rtl/mode_decode.sv
module mode_decode
   import port_role_pkg::*;
#(
   parameter int               OPC_W      = OPC_W_DEF,
   parameter logic [OPC_W-1:0] OPC_FLAGS  = OPC_FLAGS_DEF,
   parameter logic [OPC_W-1:0] OPC_DMA    = OPC_DMA_DEF,
   parameter logic [OPC_W-1:0] OPC_STATUS = OPC_STATUS_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [OPC_W-1:0] opcode,
   output logic             flag_en,
   output logic             dma_en,
   output logic             dma_cmd
);
   cmd_e cmd;

   always_comb begin
      cmd = CMD_NONE;
      if (op_valid) begin
         if (opcode == OPC_FLAGS)       cmd = CMD_FLAGS;
         else if (opcode == OPC_DMA)    cmd = CMD_DMA;
         else if (opcode == OPC_STATUS) cmd = CMD_STATUS;
      end
   end

   assign dma_cmd = (cmd == CMD_DMA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_en <= 1'b0;
         dma_en  <= 1'b0;
      end else begin
         if (cmd == CMD_FLAGS) flag_en <= 1'b1;
         if (cmd == CMD_DMA)   dma_en  <= 1'b1;
      end
   end

   // R12
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_en |=> flag_en);
   // R12
   dma_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_en |=> dma_en);
endmodule

// File: rtl/strobe_track.sv
module strobe_track #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic rd_n,
   input  logic wr_n,
   input  logic dack_n,
   output logic ack_done
);
   logic [2:0] s;      // {rd_n, wr_n, dack_n} after synchronizer
   logic       qual;
   logic       qual_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign s = {rd_n, wr_n, dack_n};
   end else begin : g_sync
      logic [SYNC_STAGES-1:0][2:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain <= '1;
         end else begin
            chain[0] <= {rd_n, wr_n, dack_n};
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign s = chain[SYNC_STAGES-1];
   end

   assign qual = enable & ~s[0] & (~s[2] | ~s[1]);

   always_ff @(posedge clk) begin
      if (!rst_n) qual_q <= 1'b0;
      else        qual_q <= qual;
   end

   assign ack_done = qual_q & ~qual;

   // R7
   ack_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done |-> enable);
endmodule

// File: rtl/drq_ctrl.sv
module drq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic dma_en,
   input  logic set_req,
   input  logic ack_done,
   input  logic dma_cmd,
   output logic drq
);
   logic raise;
   assign raise = dma_en & set_req;

   always_ff @(posedge clk) begin
      if (!rst_n)                   drq <= 1'b0;
      else if (raise)               drq <= 1'b1;
      else if (ack_done | dma_cmd)  drq <= 1'b0;
   end

   // R5
   drq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drq |-> dma_en);
   // R6
   drq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en && set_req) |=> drq);
   // R10
   drq_recmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_cmd && !set_req) |=> !drq);
   // R9
   drq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drq && !ack_done && !dma_cmd) |=> drq);
endmodule

// File: rtl/port_role_mux.sv
module port_role_mux
   import port_role_pkg::*;
#(
   parameter int               OPC_W       = OPC_W_DEF,
   parameter logic [OPC_W-1:0] OPC_FLAGS   = OPC_FLAGS_DEF,
   parameter logic [OPC_W-1:0] OPC_DMA     = OPC_DMA_DEF,
   parameter logic [OPC_W-1:0] OPC_STATUS  = OPC_STATUS_DEF,
   parameter int               SYNC_STAGES = 2,
   parameter logic [3:0]       RST_PORT    = 4'b1111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [OPC_W-1:0] opcode,
   input  logic             port_we,
   input  logic [3:0]       port_wdata,
   input  logic             ibf,
   input  logic             obf,
   input  logic             host_rd_n,
   input  logic             host_wr_n,
   input  logic             pin3_in,
   output logic [3:0]       pin_out,
   output logic [3:0]       pin_oe
);
   localparam int PIN_OBF = 0;
   localparam int PIN_IBF = 1;
   localparam int PIN_REQ = 2;
   localparam int PIN_ACK = 3;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..3");
   end
   if (OPC_FLAGS == OPC_DMA || OPC_FLAGS == OPC_STATUS || OPC_DMA == OPC_STATUS) begin : g_bad_opc
      $error("command opcodes must be distinct");
   end

   logic [3:0] port_q;
   logic       flag_en, dma_en, dma_cmd, ack_done, drq;

   always_ff @(posedge clk) begin
      if (!rst_n)       port_q <= RST_PORT;
      else if (port_we) port_q <= port_wdata;
   end

   mode_decode #(
      .OPC_W(OPC_W), .OPC_FLAGS(OPC_FLAGS), .OPC_DMA(OPC_DMA), .OPC_STATUS(OPC_STATUS)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .flag_en(flag_en), .dma_en(dma_en), .dma_cmd(dma_cmd)
   );

   strobe_track #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
      .clk(clk), .rst_n(rst_n), .enable(dma_en),
      .rd_n(host_rd_n), .wr_n(host_wr_n), .dack_n(pin3_in),
      .ack_done(ack_done)
   );

   drq_ctrl u_drq (
      .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
      .set_req(port_we & port_wdata[PIN_REQ]),
      .ack_done(ack_done), .dma_cmd(dma_cmd), .drq(drq)
   );

   always_comb begin
      pin_out          = port_q;
      pin_oe           = 4'b1111;
      if (flag_en) begin
         pin_out[PIN_OBF] = port_q[PIN_OBF] & obf;
         pin_out[PIN_IBF] = port_q[PIN_IBF] & ~ibf;
      end
      if (dma_en) begin
         pin_out[PIN_REQ] = drq;
         pin_oe[PIN_ACK]  = 1'b0;
      end
   end

   // R3
   obf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en && !port_q[PIN_OBF]) |-> !pin_out[PIN_OBF]);
   // R4
   ibf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en && ibf) |-> !pin_out[PIN_IBF]);
endmodule

// File: tb/port_role_mux_tb.sv
module port_role_mux_tb;
   localparam int         CLK_PERIOD = 10;
   localparam int         SYNC       = 2;
   localparam int         LAT        = SYNC + 1;
   localparam logic [7:0] OP_FLAGS   = 8'hF5;
   localparam logic [7:0] OP_DMA     = 8'hE5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [7:0] opcode = 8'h00;
   logic       port_we = 1'b0;
   logic [3:0] port_wdata = 4'h0;
   logic       ibf = 1'b0, obf = 1'b0;
   logic       host_rd_n = 1'b1, host_wr_n = 1'b1, pin3_in = 1'b1;
   logic [3:0] pin_out, pin_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   port_role_mux #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .port_we(port_we), .port_wdata(port_wdata), .ibf(ibf), .obf(obf),
      .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .pin3_in(pin3_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic step(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_op(input logic [7:0] code);
      opcode = code; op_valid = 1'b1; step(); op_valid = 1'b0;
   endtask

   task automatic do_wr(input logic [3:0] v);
      port_wdata = v; port_we = 1'b1; step(); port_we = 1'b0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 pins", pin_out, 4'b1111);
      chk("R1 oe", pin_oe, 4'b1111);

      // R2 plain mode sweep, status bits toggled but ignored
      for (int v = 0; v < 16; v++) begin
         obf = ~v[0]; ibf = v[1];
         do_wr(4'(v));
         chk("R2 plain", pin_out, 4'(v));
         chk("R2 oe", pin_oe, 4'b1111);
      end

      // R12 other opcodes change no mode
      do_op(8'h90);
      do_op(8'h00);
      obf = 1'b0; ibf = 1'b1;
      do_wr(4'b0011);
      chk("R12 no flag mode", pin_out, 4'b0011);
      chk("R12 no dma mode", pin_oe, 4'b1111);

      // R3 R4 flag mode sweep over port bits and status bits
      do_op(OP_FLAGS);
      for (int v = 0; v < 16; v++) begin
         for (int s = 0; s < 4; s++) begin
            obf = s[0]; ibf = s[1];
            do_wr(4'(v));
            chk("R3 R4 flags", pin_out,
                {v[3], v[2], v[1] & ~s[1], v[0] & s[0]});
         end
      end

      // R5 dma mode entry
      do_op(OP_DMA);
      chk("R5 oe", pin_oe, 4'b0111);
      chk("R5 drq idle", {3'b000, pin_out[2]}, 4'b0000);

      // R6 set and hold
      do_wr(4'b0100);
      chk("R6 set", {3'b000, pin_out[2]}, 4'b0001);
      do_wr(4'b0000);
      chk("R6 write 0 keeps", {3'b000, pin_out[2]}, 4'b0001);

      // R9 strobe without acknowledge, acknowledge without strobe
      pin3_in = 1'b1; host_rd_n = 1'b0; step(3); host_rd_n = 1'b1;
      host_wr_n = 1'b0; step(3); host_wr_n = 1'b1; step(LAT + 2);
      chk("R9 no dack", {3'b000, pin_out[2]}, 4'b0001);
      pin3_in = 1'b0; step(4); pin3_in = 1'b1; step(LAT + 2);
      chk("R9 no strobe", {3'b000, pin_out[2]}, 4'b0001);

      // R7 acknowledged read clears after LAT edges
      pin3_in = 1'b0; host_rd_n = 1'b0; step(3);
      host_rd_n = 1'b1; step(LAT - 1);
      chk("R7 before", {3'b000, pin_out[2]}, 4'b0001);
      step();
      chk("R7 cleared", {3'b000, pin_out[2]}, 4'b0000);
      pin3_in = 1'b1; step(2);

      // R8 acknowledged write
      do_wr(4'b0100);
      pin3_in = 1'b0; host_wr_n = 1'b0; step(3);
      host_wr_n = 1'b1; step(LAT - 1);
      chk("R8 before", {3'b000, pin_out[2]}, 4'b0001);
      step();
      chk("R8 cleared", {3'b000, pin_out[2]}, 4'b0000);
      pin3_in = 1'b1; step(2);

      // R10 re-issued enable clears
      do_wr(4'b0100);
      do_op(OP_DMA);
      chk("R10 cleared", {3'b000, pin_out[2]}, 4'b0000);
      chk("R10 mode kept", pin_oe, 4'b0111);

      // R11 set lands on the clearing edge of an acknowledged read
      do_wr(4'b0100);
      pin3_in = 1'b0; host_rd_n = 1'b0; step(3);
      host_rd_n = 1'b1; step(LAT - 1);
      do_wr(4'b0100);
      chk("R11 set over ack", {3'b000, pin_out[2]}, 4'b0001);
      step(LAT + 2);
      chk("R11 no stale clear", {3'b000, pin_out[2]}, 4'b0001);
      pin3_in = 1'b1; step(2);

      // R11 set together with re-issued enable
      opcode = OP_DMA; op_valid = 1'b1; port_wdata = 4'b0100; port_we = 1'b1;
      step();
      op_valid = 1'b0; port_we = 1'b0;
      chk("R11 set over cmd", {3'b000, pin_out[2]}, 4'b0001);

      // R12 modes stay on after unrelated opcodes
      do_op(8'h90);
      obf = 1'b0; ibf = 1'b0;
      do_wr(4'b0111);
      chk("R12 sticky", pin_out[2:0], 3'b110);
      chk("R12 sticky oe", pin_oe, 4'b0111);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule